// File: doc/BRIEF.md
# Sector-Range CRC Scanner

This block computes a CRC-16 over a contiguous run of 1 KB sectors in a 64 KB code memory. Software programs a first sector and an extra-sector count through a small byte-wide register port, sets the arm bit, and then writes the trigger register. The block then reads the range one byte at a time through a request/valid memory port, folds each byte into a CRC-16 (polynomial 0x1021, seeded with 0xFFFF) and raises its completion flag when the last byte has been absorbed.

The range always runs from sector `first` through sector `first + extra`, both inclusive. A sum past the top sector is clamped to sector 63. When both fields are zero the scan covers all 64 sectors. Sectors in the upper half of the space carry an external bank number on the memory port. While a scan is running the register file refuses writes, so the range and the arm state cannot change part-way through.

Top module: `crc_range_scan`

## Requirements
- R1: After reset, register 0 reads 0x40, register 1 reads 0x00, registers 2 and 3 read 0xFF, `done_o` is 1 and `mem_req_o` is 0.
- R2: Register map: 0 = control {arm bit 7, done bit 6 (read-only), first sector bits 5:0}; 1 = extra-sector count in bits 5:0; a write to 2 is the trigger. A trigger write starts a scan only when the arm bit is 1. With the arm bit 0 it starts nothing: `mem_req_o` stays 0, `done_o` stays 1 and the CRC is unchanged.
- R3: The first byte address requested is first sector × 1024.
- R4: Register 1 bits 7:6 always read 0 and ignore writes.
- R5: Addresses rise by one per accepted byte, and the scan ends after the last byte of sector first + extra. Exactly (extra + 1) × 1024 bytes are read.
- R6: `done_o` and control bit 6 are 0 from the cycle after the trigger until the last byte is accepted. They return to 1 on the edge that absorbs the last byte. `done_o` is 1 exactly when `mem_req_o` is 0.
- R7: When first and extra are both 0, the scan covers all 64 sectors starting at address 0 (65536 bytes).
- R8: `mem_bank_o` equals `bank_sel_i` while the address is in sectors 32 to 63. It is 0 for sectors 0 to 31.
- R9: If first + extra exceeds 63, the last sector scanned is 63 and the address never wraps.
- R10: The CRC is CRC-16 with polynomial 0x1021, processed MSB first one byte per accepted read, and seeded to 0xFFFF when a scan starts. It reads at `crc_o`, register 2 (low byte) and register 3 (high byte), and it holds its value until the next scan starts.
- R11: `mem_req_o` stays high with `mem_addr_o` stable until `mem_valid_i` is seen. A byte is accepted in a cycle where both are high, so at most one read is outstanding.
- R12: While a scan is running, writes to registers 0, 1 and 2 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational on address) |
| bank_sel_i | input | 2 | Bank number used for sectors 32 to 63 |
| mem_req_o | output | 1 | Read request, held until accepted |
| mem_addr_o | output | 16 | Byte address of the pending read |
| mem_bank_o | output | 2 | Bank number of the pending read |
| mem_valid_i | input | 1 | Read data valid; accepts the pending request |
| mem_data_i | input | 8 | Read data byte |
| crc_o | output | 16 | Current CRC value |
| done_o | output | 1 | Scan complete / idle |

## Verification
The bench targets the range ends. A zero first/extra pair must cover all 64 sectors; a design that treats it literally reads only 1 KB and gives the wrong CRC and byte count. A first sector near the top must clamp to 63; a design that wraps reads past address 0xFFFF, back into low memory. A range that crosses sector 32 shows whether the bank number switches at the right byte. A run with random wait states shows whether the address moves before the data arrives. Trigger writes with the arm bit clear, and writes made during a busy scan, must leave the outputs and the programmed fields as they were. A design that lets them through starts a stray scan or reads back altered fields.

// File: rtl/crc_range_pkg.sv
package crc_range_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_CNT  = 2'd1,
    REG_TRIG = 2'd2,
    REG_CRCH = 2'd3
  } reg_sel_e;

  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;
endpackage

// File: rtl/crc_range_regs.sv
module crc_range_regs
  import crc_range_pkg::*;
#(
  parameter int SECT_W = 6,
  parameter int CRC_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              last_i,
  input  logic [CRC_W-1:0]  crc_i,
  output logic              launch_o,
  output logic [SECT_W-1:0] first_o,
  output logic [SECT_W-1:0] extra_o,
  output logic              done_o
);
  logic              arm_q;
  logic              done_q;
  logic [SECT_W-1:0] first_q;
  logic [SECT_W-1:0] extra_q;
  logic              wr_ok;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata_i;
  assign wr_ok    = reg_wr_i && done_q;   // busy lockout
  assign launch_o = wr_ok && arm_q && (reg_sel_e'(reg_addr_i) == REG_TRIG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q   <= 1'b0;
      done_q  <= 1'b1;
      first_q <= '0;
      extra_q <= '0;
    end else begin
      if (wr_ok) begin
        case (reg_sel_e'(reg_addr_i))
          REG_CTRL: begin
            arm_q   <= reg_wdata_i[7];
            first_q <= reg_wdata_i[SECT_W-1:0];
          end
          REG_CNT:  extra_q <= reg_wdata_i[SECT_W-1:0];
          default:  ;
        endcase
      end
      if (launch_o)    done_q <= 1'b0;
      else if (last_i) done_q <= 1'b1;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_sel_e'(reg_addr_i))
      REG_CTRL: begin
        reg_rdata_o[7]          = arm_q;
        reg_rdata_o[6]          = done_q;
        reg_rdata_o[SECT_W-1:0] = first_q;
      end
      REG_CNT:  reg_rdata_o[SECT_W-1:0] = extra_q;
      REG_TRIG: reg_rdata_o = crc_i[7:0];
      REG_CRCH: reg_rdata_o = crc_i[CRC_W-1:CRC_W-8];
      default:  reg_rdata_o = '0;
    endcase
  end

  assign first_o = first_q;
  assign extra_o = extra_q;
  assign done_o  = done_q;
endmodule

// File: rtl/crc_range_seq.sv
module crc_range_seq #(
  parameter int SECT_W = 6,
  parameter int OFS_W  = 10,
  parameter int BANK_W = 2,
  localparam int ADDR_W = SECT_W + OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic [SECT_W-1:0] first_i,
  input  logic [SECT_W-1:0] extra_i,
  input  logic [BANK_W-1:0] bank_sel_i,
  input  logic              mem_valid_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BANK_W-1:0] mem_bank_o,
  output logic              take_o,
  output logic              last_o
);
  localparam logic [SECT_W-1:0] SECT_MAX = {SECT_W{1'b1}};

  logic              busy_q;
  logic [ADDR_W-1:0] addr_q;
  logic [SECT_W-1:0] end_q;
  logic [SECT_W:0]   sum;
  logic [SECT_W-1:0] end_sec;

  always_comb begin
    sum = {1'b0, first_i} + {1'b0, extra_i};
    if (first_i == '0 && extra_i == '0)  end_sec = SECT_MAX;   // whole space
    else if (sum > {1'b0, SECT_MAX})     end_sec = SECT_MAX;   // clamp, no wrap
    else                                 end_sec = sum[SECT_W-1:0];
  end

  assign take_o = busy_q && mem_valid_i;
  assign last_o = take_o && (addr_q == {end_q, {OFS_W{1'b1}}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      addr_q <= '0;
      end_q  <= '0;
    end else if (launch_i) begin
      busy_q <= 1'b1;
      addr_q <= {first_i, {OFS_W{1'b0}}};
      end_q  <= end_sec;
    end else if (take_o) begin
      if (last_o) busy_q <= 1'b0;
      else        addr_q <= addr_q + 1'b1;
    end
  end

  assign mem_req_o  = busy_q;
  assign mem_addr_o = addr_q;
  assign mem_bank_o = addr_q[ADDR_W-1] ? bank_sel_i : '0;
endmodule

// File: rtl/crc_range_crc16.sv
module crc_range_crc16
  import crc_range_pkg::*;
#(
  parameter int               CRC_W = 16,
  parameter int               DW    = 8,
  parameter logic [CRC_W-1:0] POLY  = CRC_POLY,
  parameter logic [CRC_W-1:0] SEED  = CRC_SEED
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             seed_i,
  input  logic             take_i,
  input  logic [DW-1:0]    data_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] stg [DW+1];

  assign stg[0] = crc_q ^ {data_i, {(CRC_W-DW){1'b0}}};

  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign stg[i+1] = stg[i][CRC_W-1] ? ((stg[i] << 1) ^ POLY) : (stg[i] << 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= SEED;
    else if (seed_i) crc_q <= SEED;
    else if (take_i) crc_q <= stg[DW];
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/crc_range_scan.sv
module crc_range_scan #(
  parameter int SECT_W = 6,
  parameter int OFS_W  = 10,
  parameter int BANK_W = 2,
  parameter int CRC_W  = 16,
  localparam int ADDR_W = SECT_W + OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic [BANK_W-1:0] bank_sel_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BANK_W-1:0] mem_bank_o,
  input  logic              mem_valid_i,
  input  logic [7:0]        mem_data_i,
  output logic [CRC_W-1:0]  crc_o,
  output logic              done_o
);
  logic              launch;
  logic              take;
  logic              last;
  logic [SECT_W-1:0] first;
  logic [SECT_W-1:0] extra;

  crc_range_regs #(.SECT_W(SECT_W), .CRC_W(CRC_W)) i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .last_i      (last),
    .crc_i       (crc_o),
    .launch_o    (launch),
    .first_o     (first),
    .extra_o     (extra),
    .done_o      (done_o)
  );

  crc_range_seq #(.SECT_W(SECT_W), .OFS_W(OFS_W), .BANK_W(BANK_W)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .launch_i    (launch),
    .first_i     (first),
    .extra_i     (extra),
    .bank_sel_i  (bank_sel_i),
    .mem_valid_i (mem_valid_i),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_bank_o  (mem_bank_o),
    .take_o      (take),
    .last_o      (last)
  );

  crc_range_crc16 #(.CRC_W(CRC_W), .DW(8)) i_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .seed_i (launch),
    .take_i (take),
    .data_i (mem_data_i),
    .crc_o  (crc_o)
  );
endmodule

// File: rtl/crc_range_scan_chk.sv
module crc_range_scan_chk #(
  parameter int ADDR_W = 16,
  parameter int CRC_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic [1:0]        reg_addr_i,
  input logic              mem_req_o,
  input logic              mem_valid_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [CRC_W-1:0]  crc_o,
  input logic              done_o
);
  assert_req_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  assert_addr_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_valid_i) |=> (!mem_req_o || mem_addr_o == $past(mem_addr_o) + 1'b1));

  assert_done_vs_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o == !mem_req_o);

  assert_start_from_trig_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> $past(reg_wr_i && reg_addr_i == 2'd2));

  assert_sector_aligned_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> (mem_addr_o[9:0] == '0));

  assert_seed_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> (crc_o == 16'hFFFF));

  assert_crc_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(done_o)) |-> $stable(crc_o));
endmodule

bind crc_range_scan crc_range_scan_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .mem_req_o   (mem_req_o),
  .mem_valid_i (mem_valid_i),
  .mem_addr_o  (mem_addr_o),
  .crc_o       (crc_o),
  .done_o      (done_o)
);

// File: tb/test_crc_range_scan.sv
`timescale 1ns/1ps
module test_crc_range_scan;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic [1:0]  bank_sel_i = 2'b10;
  logic        mem_req_o;
  logic [15:0] mem_addr_o;
  logic [1:0]  mem_bank_o;
  logic        mem_valid_i;
  logic [7:0]  mem_data_i;
  logic [15:0] crc_o;
  logic        done_o;

  int total = 0;
  int bad   = 0;

  always #5 clk_i = ~clk_i;

  crc_range_scan i_crc_range_scan (.*);

  // memory model
  logic       stall_on = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  always @(posedge clk_i) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};

  function automatic logic [7:0] mem_byte(input logic [15:0] a, input logic [1:0] b);
    return a[7:0] ^ {a[15:10], a[1:0]} ^ {b, 6'h0};
  endfunction

  assign mem_valid_i = mem_req_o & (stall_on ? lfsr[0] : 1'b1);
  assign mem_data_i  = mem_byte(mem_addr_o, mem_bank_o);

  // monitor
  logic [15:0] exp_addr;
  logic [15:0] first_addr;
  logic [15:0] held;
  logic        waiting = 1'b0;
  int nbytes = 0, addr_err = 0, bank_err = 0, hold_err = 0;

  always @(negedge clk_i) begin
    if (mem_req_o && !mem_valid_i) begin
      if (waiting && mem_addr_o != held) hold_err++;
      waiting = 1'b1;
      held = mem_addr_o;
    end else if (mem_req_o && mem_valid_i) begin
      if (waiting && mem_addr_o != held) hold_err++;
      waiting = 1'b0;
      if (nbytes == 0) first_addr = mem_addr_o;
      if (mem_addr_o != exp_addr) addr_err++;
      if (mem_bank_o != (mem_addr_o[15] ? bank_sel_i : 2'b00)) bank_err++;
      exp_addr = exp_addr + 16'd1;
      nbytes++;
    end else begin
      waiting = 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] x;
    x = c ^ {d, 8'h00};
    for (int k = 0; k < 8; k++) x = x[15] ? ((x << 1) ^ 16'h1021) : (x << 1);
    return x;
  endfunction

  function automatic logic [15:0] crc_range(input int s0, input int s1, input logic [1:0] b);
    logic [15:0] c = 16'hFFFF;
    for (int s = s0; s <= s1; s++)
      for (int o = 0; o < 1024; o++) begin
        logic [15:0] a;
        a = 16'(s * 1024 + o);
        c = crc_step(c, mem_byte(a, (s >= 32) ? b : 2'b00));
      end
    return c;
  endfunction

  logic [15:0] last_crc;

  task automatic run_scan(input int st, input int ct, input int s0, input int s1, input string tag);
    logic [7:0] d, lo, hi;
    logic [15:0] ecrc;
    ecrc = crc_range(s0, s1, bank_sel_i);
    wr(2'd0, 8'h80 | 8'(st));
    wr(2'd1, 8'(ct));
    exp_addr = 16'(s0 * 1024);
    nbytes = 0; addr_err = 0; bank_err = 0; hold_err = 0;
    wr(2'd2, 8'h00);
    chk({tag, " R6 busy done_o"}, done_o, 0);
    rd(2'd0, d);
    chk({tag, " R6 busy ctrl bit6"}, d[6], 0);
    while (!done_o) @(negedge clk_i);
    chk({tag, " R3 first address"}, first_addr, 32'(s0 * 1024));
    chk({tag, " R5 byte count"}, nbytes, 32'((s1 - s0 + 1) * 1024));
    chk({tag, " R5 address order"}, addr_err, 0);
    chk({tag, " R8 bank"}, bank_err, 0);
    chk({tag, " R11 hold"}, hold_err, 0);
    chk({tag, " R10 crc_o"}, crc_o, ecrc);
    rd(2'd2, lo);
    rd(2'd3, hi);
    chk({tag, " R10 crc regs"}, {hi, lo}, ecrc);
    rd(2'd0, d);
    chk({tag, " R6 done after"}, d[6], 1);
    last_crc = ecrc;
  endtask

  // {first, extra, exp_first, exp_last}
  localparam logic [23:0] VEC [6] = '{
    {6'd5,  6'd2, 6'd5,  6'd7},
    {6'd0,  6'd0, 6'd0,  6'd63},
    {6'd62, 6'd5, 6'd62, 6'd63},
    {6'd40, 6'd0, 6'd40, 6'd40},
    {6'd31, 6'd1, 6'd31, 6'd32},
    {6'd0,  6'd1, 6'd0,  6'd1}
  };
  localparam string VTAG [6] = '{"R5 span", "R7 full", "R9 clamp", "R2 single", "R8 cross", "R3 low"};

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    rd(2'd0, d); chk("R1 ctrl reset", d, 8'h40);
    rd(2'd1, d); chk("R1 count reset", d, 8'h00);
    rd(2'd2, d); chk("R1 crc low reset", d, 8'hFF);
    rd(2'd3, d); chk("R1 crc high reset", d, 8'hFF);
    chk("R1 done_o reset", done_o, 1);
    chk("R1 req reset", mem_req_o, 0);

    // R4 count upper bits
    wr(2'd1, 8'hFF);
    rd(2'd1, d); chk("R4 count mask", d, 8'h3F);

    // R2 trigger with arm clear
    wr(2'd0, 8'h05);
    wr(2'd2, 8'h00);
    @(negedge clk_i);
    chk("R2 disarmed req", mem_req_o, 0);
    chk("R2 disarmed done", done_o, 1);
    chk("R2 disarmed crc", crc_o, 16'hFFFF);
    rd(2'd0, d); chk("R2 disarmed ctrl", d, 8'h45);

    for (int i = 0; i < 6; i++)
      run_scan(int'(VEC[i][23:18]), int'(VEC[i][17:12]), int'(VEC[i][11:6]), int'(VEC[i][5:0]), VTAG[i]);

    // R10 hold after completion
    repeat (20) @(negedge clk_i);
    chk("R10 crc held", crc_o, last_crc);

    // R11 wait states
    stall_on = 1'b1;
    run_scan(2, 1, 2, 3, "R11 stall");
    stall_on = 1'b0;

    // R12 writes during busy
    wr(2'd0, 8'h83);
    wr(2'd1, 8'h00);
    exp_addr = 16'(3 * 1024);
    nbytes = 0; addr_err = 0;
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h8A);
    wr(2'd1, 8'h05);
    wr(2'd2, 8'h00);
    while (!done_o) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
    chk("R12 req idle", mem_req_o, 0);
    chk("R12 byte count", nbytes, 1024);
    chk("R12 address order", addr_err, 0);
    rd(2'd0, d); chk("R12 ctrl kept", d, 8'hC3);
    rd(2'd1, d); chk("R12 count kept", d, 8'h00);
    chk("R12 crc", crc_o, crc_range(3, 3, bank_sel_i));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule